// File: doc/BRIEF.md
# Write-Only Serial Control-Register Slave

This block is a receive-only slave on a two-wire serial bus (I2C-style: a clock line and an open-drain data line). A host uses it to write 16-bit words into a bank of control registers inside the core. Both bus lines are sampled by a much faster system clock. Each line first passes through a two-flop synchronizer and then a short persistence filter. Start, stop and clock-edge events come from the filtered levels.

A write transfer has the following parts. A start condition. An address byte whose upper seven bits must equal a fixed 5-bit prefix followed by two strap pins. A sub-address byte that picks the first register. Then any number of byte pairs: each pair is a high byte followed by a low byte. After every complete pair the block presents the register index and the 16-bit word with a one-cycle strobe. It then advances the index, so the next pair writes the next register. A stop or a repeated start may arrive at any point. A half-received word is dropped.

The only drive the block puts on the bus is an active-high pull-down enable for acknowledge bits. The system clock must run at least 16 times the bus clock rate.

Top module: `serial_regwr_slave`

## Requirements
- R1: After reset the pull-down enable and the write strobe are both low.
- R2: The address byte is acknowledged only when its bits 7..1 equal the prefix 5'b10011 followed by strap[1:0] (strap[1] at bit 2, strap[0] at bit 1), and its bit 0 (the direction bit) is 0.
- R3: After an address byte that does not match, or whose bit 0 is 1, no later byte is acknowledged and no strobe fires until the next start or stop.
- R4: After a matching address, the block acknowledges the sub-address byte and each data byte. The sub-address value becomes the index of the first word written.
- R5: The first data byte of a pair forms word bits 15..8 and the second forms bits 7..0. Exactly one strobe, one system clock wide, fires per completed pair, and the index and word are valid in that cycle.
- R6: After each strobed word the index increases by one, so further pairs go to consecutive registers.
- R7: A stop after an odd number of data bytes produces no strobe, and the dropped byte does not affect the next transfer.
- R8: A repeated start in the middle of a transfer restarts address reception. The bytes received before it produce no strobe.
- R9: The pull-down enable is asserted only for acknowledge bits. It rises and falls only while the bus clock is low, and it is low during every data bit's clock-high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (at least 16x bus clock rate) |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap_i | input | 2 | Pin-strapped low address bits {A1, A0} |
| sda_pull_o | output | 1 | Active-high enable for the data-line pull-down |
| wr_idx_o | output | 8 | Register index for the current word |
| wr_data_o | output | 16 | 16-bit register word |
| wr_stb_o | output | 1 | One-cycle latch strobe |

## Verification
Each line change reaches the event logic about five system clocks late: two synchronizer flops, a three-sample filter, and the edge register. Every bus half-phase in the bench lasts 20 or 40 system clocks, so the filtered events settle well before the bench samples. The acknowledge is sampled 20 clocks into the ninth clock-high phase. By then the pull-down, which was raised at the filtered fall before that phase, is stable. Strobes occur at the filtered eighth rise of the low byte. A monitor records them, and the bench compares the recorded count, indices and words only after the byte or the stop has fully ended.

// File: rtl/regwr_pkg.sv
package regwr_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;
    localparam int IDX_W  = 8;

    typedef enum logic [1:0] {
        PH_DEV,
        PH_SEL,
        PH_UPPER,
        PH_LOWER
    } field_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT,
        ST_ACKWAIT,
        ST_ACK,
        ST_SKIP
    } rx_state_e;

    typedef struct packed {
        logic begin_ev;
        logic end_ev;
        logic clk_rise;
        logic clk_fall;
    } bus_ev_t;

    function automatic logic dev_hit(input logic [BYTE_W-1:0] b,
                                     input logic [4:0] prefix,
                                     input logic [1:0] strap);
        return (b[7:1] == {prefix, strap}) && (b[0] == 1'b0);
    endfunction

endpackage

// File: rtl/regwr_line_filter.sv
module regwr_line_filter #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic level_o
);
    localparam int CNT_W = $clog2(HOLD + 1);

    logic             sync_a, sync_b;
    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a  <= 1'b1;
            sync_b  <= 1'b1;
            run_cnt <= '0;
            level_o <= 1'b1;
        end else begin
            sync_a <= raw_i;
            sync_b <= sync_a;
            if (sync_b == level_o) begin
                run_cnt <= '0;
            end else if (run_cnt == CNT_W'(HOLD - 1)) begin
                level_o <= sync_b;
                run_cnt <= '0;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/regwr_bus_events.sv
module regwr_bus_events
    import regwr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev_o
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev_o.begin_ev = scl_f & scl_q & sda_q & ~sda_f;
        ev_o.end_ev   = scl_f & scl_q & ~sda_q & sda_f;
        ev_o.clk_rise = scl_f & ~scl_q;
        ev_o.clk_fall = ~scl_f & scl_q;
    end
endmodule

// File: rtl/serial_regwr_slave.sv
module serial_regwr_slave
    import regwr_pkg::*;
#(
    parameter logic [4:0] DEV_PREFIX = 5'b10011,
    parameter int         FILT_HOLD  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        strap_i,
    output logic              sda_pull_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [WORD_W-1:0] wr_data_o,
    output logic              wr_stb_o
);
    localparam int BIT_CW = $clog2(BYTE_W);

    logic    scl_f, sda_f;
    bus_ev_t ev;

    regwr_line_filter #(.HOLD(FILT_HOLD)) u_scl_flt (
        .clk(clk), .rst(rst), .raw_i(scl_i), .level_o(scl_f)
    );
    regwr_line_filter #(.HOLD(FILT_HOLD)) u_sda_flt (
        .clk(clk), .rst(rst), .raw_i(sda_i), .level_o(sda_f)
    );
    regwr_bus_events u_ev (
        .clk(clk), .rst(rst), .scl_f(scl_f), .sda_f(sda_f), .ev_o(ev)
    );

    rx_state_e           state;
    field_e              field;
    logic [BIT_CW-1:0]   bit_cnt;
    logic [BYTE_W-1:0]   shreg;
    logic [BYTE_W-1:0]   upper_q;
    logic                step_pend;
    logic [BYTE_W-1:0]   got;

    assign got = {shreg[BYTE_W-2:0], sda_f};

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            field      <= PH_DEV;
            bit_cnt    <= '0;
            shreg      <= '0;
            upper_q    <= '0;
            step_pend  <= 1'b0;
            wr_idx_o   <= '0;
            wr_data_o  <= '0;
            wr_stb_o   <= 1'b0;
            sda_pull_o <= 1'b0;
        end else begin
            wr_stb_o <= 1'b0;
            if (ev.end_ev) begin
                state      <= ST_IDLE;
                sda_pull_o <= 1'b0;
                step_pend  <= 1'b0;
            end else if (ev.begin_ev) begin
                state      <= ST_SHIFT;
                field      <= PH_DEV;
                bit_cnt    <= '0;
                sda_pull_o <= 1'b0;
                step_pend  <= 1'b0;
            end else begin
                case (state)
                    ST_SHIFT: begin
                        if (ev.clk_rise) begin
                            shreg <= got;
                            if (bit_cnt == BIT_CW'(BYTE_W - 1)) begin
                                bit_cnt <= '0;
                                state   <= ST_ACKWAIT;
                                case (field)
                                    PH_DEV: begin
                                        if (dev_hit(got, DEV_PREFIX, strap_i))
                                            field <= PH_SEL;
                                        else
                                            state <= ST_SKIP;
                                    end
                                    PH_SEL: begin
                                        wr_idx_o <= got;
                                        field    <= PH_UPPER;
                                    end
                                    PH_UPPER: begin
                                        upper_q <= got;
                                        field   <= PH_LOWER;
                                    end
                                    default: begin
                                        wr_data_o <= {upper_q, got};
                                        wr_stb_o  <= 1'b1;
                                        step_pend <= 1'b1;
                                        field     <= PH_UPPER;
                                    end
                                endcase
                            end else begin
                                bit_cnt <= bit_cnt + 1'b1;
                            end
                        end
                    end
                    ST_ACKWAIT: begin
                        if (ev.clk_fall) begin
                            sda_pull_o <= 1'b1;
                            state      <= ST_ACK;
                        end
                    end
                    ST_ACK: begin
                        if (ev.clk_fall) begin
                            sda_pull_o <= 1'b0;
                            state      <= ST_SHIFT;
                            if (step_pend) begin
                                wr_idx_o  <= wr_idx_o + 1'b1;
                                step_pend <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/regwr_checker.sv
module regwr_checker (
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_pull_o,
    input logic wr_stb_o
);
    // R5: strobe lasts exactly one cycle
    p_stb_single_r5: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !wr_stb_o);

    // R5: a strobe falls in a data bit, never while acknowledging
    p_stb_no_pull_r5: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> !sda_pull_o);

    // R9: pull-down engages only while the bus clock is low
    p_pull_rise_low_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull_o) |-> !scl_i);

    // R9: pull-down lets go only while the bus clock is low
    p_pull_fall_low_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_pull_o) |-> !scl_i);
endmodule

bind serial_regwr_slave regwr_checker u_chk (
    .clk(clk), .rst(rst), .scl_i(scl_i),
    .sda_pull_o(sda_pull_o), .wr_stb_o(wr_stb_o)
);

// File: tb/serial_regwr_slave_test.sv
module serial_regwr_slave_test;
    localparam logic [4:0] PFX = 5'b10011;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  strap = 2'd0;
    logic        sda_pull_o;
    logic [7:0]  wr_idx_o;
    logic [15:0] wr_data_o;
    logic        wr_stb_o;
    logic        sda_bus;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    assign sda_bus = sda_m & ~sda_pull_o;

    always #2 clk = ~clk;

    serial_regwr_slave uut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .strap_i(strap), .sda_pull_o(sda_pull_o), .wr_idx_o(wr_idx_o),
        .wr_data_o(wr_data_o), .wr_stb_o(wr_stb_o)
    );

    // output monitor
    int          stb_cnt = 0;
    logic [7:0]  rec_idx [0:15];
    logic [15:0] rec_dat [0:15];
    logic        prev_stb = 1'b0;
    bit          wide_stb = 0;

    always @(posedge clk) begin
        prev_stb <= wr_stb_o;
        if (wr_stb_o && prev_stb) wide_stb <= 1;
        if (wr_stb_o) begin
            if (stb_cnt < 16) begin
                rec_idx[stb_cnt] <= wr_idx_o;
                rec_dat[stb_cnt] <= wr_data_o;
            end
            stb_cnt <= stb_cnt + 1;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(20);
        scl_m = 1'b1; tick(20);
        sda_m = 1'b0; tick(20);
        scl_m = 1'b0; tick(20);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(20);
        scl_m = 1'b1; tick(20);
        sda_m = 1'b1; tick(40);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, output logic pulled);
        pulled = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(20);
            scl_m = 1'b1; tick(20);
            if (sda_pull_o) pulled = 1'b1;
            tick(20);
            scl_m = 1'b0; tick(20);
        end
        sda_m = 1'b1; tick(20);
        scl_m = 1'b1; tick(20);
        ack = sda_pull_o;
        tick(20);
        scl_m = 1'b0; tick(20);
    endtask

    task automatic wr_byte(input logic [7:0] b, input bit exp_ack, input string req);
        logic a, p;
        send_byte(b, a, p);
        check(a == exp_ack, req, a, exp_ack);
        check(!p, "R9", p, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int base;
        tick(5);
        rst = 1'b0;
        tick(5);
        // R1: quiet after reset
        check(!sda_pull_o && !wr_stb_o, "R1", {sda_pull_o, wr_stb_o}, 0);

        // R2 / R3: exhaustive strap vs address suffix sweep
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            for (int a = 0; a < 4; a++) begin
                bus_start();
                wr_byte({PFX, 2'(a), 1'b0}, (a == s), "R2");
                wr_byte(8'h05, (a == s), "R3");
                bus_stop();
            end
        end
        check(stb_cnt == 0, "R3", stb_cnt, 0);

        // R4 / R5 / R6: burst of three words
        strap = 2'd2;
        bus_start();
        wr_byte({PFX, 2'd2, 1'b0}, 1, "R2");
        wr_byte(8'h10, 1, "R4");
        wr_byte(8'hA5, 1, "R4"); wr_byte(8'h5A, 1, "R4");
        wr_byte(8'h00, 1, "R4"); wr_byte(8'h01, 1, "R4");
        wr_byte(8'hFF, 1, "R4"); wr_byte(8'hFF, 1, "R4");
        bus_stop();
        check(stb_cnt == 3, "R5", stb_cnt, 3);
        check(rec_idx[0] == 8'h10, "R4", rec_idx[0], 8'h10);
        check(rec_dat[0] == 16'hA55A, "R5", rec_dat[0], 16'hA55A);
        check(rec_idx[1] == 8'h11, "R6", rec_idx[1], 8'h11);
        check(rec_dat[1] == 16'h0001, "R5", rec_dat[1], 16'h0001);
        check(rec_idx[2] == 8'h12, "R6", rec_idx[2], 8'h12);
        check(rec_dat[2] == 16'hFFFF, "R5", rec_dat[2], 16'hFFFF);
        check(!wide_stb, "R5", wide_stb, 0);

        // R3: direction bit set
        bus_start();
        wr_byte({PFX, 2'd2, 1'b1}, 0, "R3");
        wr_byte(8'h20, 0, "R3");
        wr_byte(8'h12, 0, "R3"); wr_byte(8'h34, 0, "R3");
        bus_stop();
        check(stb_cnt == 3, "R3", stb_cnt, 3);

        // R7: odd byte then stop
        bus_start();
        wr_byte({PFX, 2'd2, 1'b0}, 1, "R2");
        wr_byte(8'h20, 1, "R4");
        wr_byte(8'h77, 1, "R4");
        bus_stop();
        check(stb_cnt == 3, "R7", stb_cnt, 3);
        bus_start();
        wr_byte({PFX, 2'd2, 1'b0}, 1, "R2");
        wr_byte(8'h20, 1, "R4");
        wr_byte(8'h12, 1, "R4"); wr_byte(8'h34, 1, "R4");
        bus_stop();
        check(stb_cnt == 4, "R7", stb_cnt, 4);
        check(rec_idx[3] == 8'h20, "R7", rec_idx[3], 8'h20);
        check(rec_dat[3] == 16'h1234, "R7", rec_dat[3], 16'h1234);

        // R8: repeated start mid-word
        bus_start();
        wr_byte({PFX, 2'd2, 1'b0}, 1, "R2");
        wr_byte(8'h30, 1, "R4");
        wr_byte(8'h99, 1, "R4");
        bus_start();
        check(stb_cnt == 4, "R8", stb_cnt, 4);
        wr_byte({PFX, 2'd2, 1'b0}, 1, "R8");
        wr_byte(8'h40, 1, "R8");
        wr_byte(8'hBE, 1, "R8"); wr_byte(8'hEF, 1, "R8");
        bus_stop();
        check(stb_cnt == 5, "R8", stb_cnt, 5);
        check(rec_idx[4] == 8'h40, "R8", rec_idx[4], 8'h40);
        check(rec_dat[4] == 16'hBEEF, "R8", rec_dat[4], 16'hBEEF);

        // R5 / R6: walking-one words through consecutive registers
        base = stb_cnt;
        bus_start();
        wr_byte({PFX, 2'd2, 1'b0}, 1, "R2");
        wr_byte(8'hFE, 1, "R4");
        for (int k = 0; k < 3; k++) begin
            wr_byte(8'(1 << k), 1, "R5");
            wr_byte(8'(8'h80 >> k), 1, "R5");
        end
        bus_stop();
        for (int k = 0; k < 3; k++) begin
            check(rec_idx[base + k] == 8'(8'hFE + k), "R6", rec_idx[base + k], 8'hFE + k);
            check(rec_dat[base + k] == {8'(1 << k), 8'(8'h80 >> k)}, "R5",
                  rec_dat[base + k], {8'(1 << k), 8'(8'h80 >> k)});
        end
        check(!sda_pull_o, "R9", sda_pull_o, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule